// File: doc/BRIEF.md
# Sub-cycle timed D flip-flop

This block models a D flip-flop whose clock, data and output are not plain wires but per-cycle edge descriptions. Each cycle of a fixed reference clock is split into 2^OFF_W offset steps. A signal is carried as its level at the end of the cycle plus a short list of transition slots. Each slot has a valid bit and the offset at which the level toggles. The block finds the active edges of the described clock, samples the described data at those offsets, and produces the described output in the same reference cycle.

The flip-flop's state crosses reference-cycle boundaries through a single feedback register, clocked by the reference clock. This register holds the final output level of one cycle and supplies it as the starting level of the next. It is the only storage in the block, so the path from inputs to output contains no combinational loop. A parameter selects whether rising edges, falling edges or both edges are active.

Top module: `timed_dff`

## Requirements
- R1: Encoding. A described signal carries `lvl`, its level at the end of the reference cycle, and per slot i a valid bit `vld[i]` and an offset at bits `[i*OFF_W +: OFF_W]`. Offset 0 means the reference edge itself. The level at the start of the cycle is `lvl` XOR the parity of the valid bits. Clock slots are filled from slot 0 in ascending offset order. Data slots may be in any order.
- R2: An active clock edge at offset k captures the data level in effect at offset k. Only data transitions with offset strictly below k count, so a data transition at exactly k takes effect after the capture.
- R3: The output is produced in the same reference cycle. A Q transition appears at the offset of each active edge whose captured value differs from the Q level before that edge. Slot 0 fills first. `eq_lvl` is the final Q level.
- R4: The Q level at the start of each cycle equals the final Q level of the previous cycle. A cycle without active clock edges has no Q transitions and keeps the level.
- R5: In the default rising-edge mode, falling clock transitions have no effect on Q.
- R6: In both-edge mode every one of the first two clock transitions is active, so Q can carry two transitions in one cycle.
- R7: `clk_err` is raised in the same cycle in two cases. The first is when more than two clock slots are valid. The second is when the valid clock slots are not contiguous from slot 0 or not in ascending offset order. Clock slots beyond the first two never affect Q.
- R8: When every transition sits at offset 0, the block acts as a plain cycle-based D flip-flop. A rising clock captures the data level from before that cycle's data change.
- R9: Synchronous active-high reset sets the held Q level to INIT_Q (0 by default). After reset, an idle cycle shows that level with no Q transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| eclk_lvl | input | 1 | Clock level at end of cycle |
| eclk_vld | input | CLK_SLOTS | Clock transition valid bits |
| eclk_off | input | CLK_SLOTS*OFF_W | Clock transition offsets |
| ed_lvl | input | 1 | Data level at end of cycle |
| ed_vld | input | DAT_SLOTS | Data transition valid bits |
| ed_off | input | DAT_SLOTS*OFF_W | Data transition offsets |
| eq_lvl | output | 1 | Q level at end of cycle |
| eq_vld | output | 2 | Q transition valid bits |
| eq_off | output | 2*OFF_W | Q transition offsets |
| clk_err | output | 1 | Clock description violates the two-transition or ordering rule |

## Verification
A capturing clock edge and a data transition can fall on the same offset in the same cycle. This is where the sampling order decides the result. The bench places a rising edge and a data toggle together at offset 4, and again at offset 0 in the plain flip-flop case. It judges that Q takes the level from before the toggle. It also overlaps an over-full clock list with a capture, to confirm that the error flag and the capture of the first two slots happen together while the later slots stay ignored.

// File: rtl/tdff_pkg.sv
`timescale 1ns/1ps
package tdff_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } tdff_edge_e;

  // number of clock slots the cell honours per reference cycle
  localparam int unsigned ACT_SLOTS = 2;
endpackage

// File: rtl/tdff_edge_find.sv
`timescale 1ns/1ps
module tdff_edge_find
  import tdff_pkg::*;
#(
  parameter int unsigned OW = 3,
  parameter int unsigned CS = 4,
  parameter tdff_edge_e  MODE = EDGE_RISE
) (
  input  logic                          lvl,
  input  logic [CS-1:0]                 vld,
  input  logic [CS*OW-1:0]              off,
  output logic [ACT_SLOTS-1:0]          act_vld,
  output logic [ACT_SLOTS-1:0][OW-1:0]  act_off,
  output logic                          bad
);
  logic start;
  logic too_many;
  logic misorder;

  assign start = lvl ^ (^vld);

  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < CS; i++) begin
      if (vld[i]) cnt = cnt + 1;
    end
    too_many = (cnt > int'(ACT_SLOTS));
  end

  always_comb begin
    misorder = 1'b0;
    for (int i = 0; i + 1 < CS; i++) begin
      if (vld[i+1] && (!vld[i] || (off[(i+1)*OW +: OW] < off[i*OW +: OW])))
        misorder = 1'b1;
    end
  end

  assign bad = too_many | misorder;

  for (genvar s = 0; s < ACT_SLOTS; s++) begin : g_off
    assign act_off[s] = off[s*OW +: OW];
  end

  // slot 0 leaves the start level, slot 1 returns to it
  if (MODE == EDGE_RISE) begin : g_rise
    assign act_vld = {vld[1] & start, vld[0] & ~start};
  end else if (MODE == EDGE_FALL) begin : g_fall
    assign act_vld = {vld[1] & ~start, vld[0] & start};
  end else begin : g_both
    assign act_vld = vld[1:0];
  end
endmodule

// File: rtl/tdff_level_at.sv
`timescale 1ns/1ps
module tdff_level_at #(
  parameter int unsigned OW = 3,
  parameter int unsigned DS = 2
) (
  input  logic            lvl,
  input  logic [DS-1:0]   vld,
  input  logic [DS*OW-1:0] off,
  input  logic [OW-1:0]   at,
  output logic            lvl_at
);
  logic start;
  logic flips;

  assign start = lvl ^ (^vld);

  always_comb begin
    flips = 1'b0;
    for (int i = 0; i < DS; i++) begin
      if (vld[i] && (off[i*OW +: OW] < at)) flips = ~flips;
    end
  end

  assign lvl_at = start ^ flips;
endmodule

// File: rtl/tdff_q_merge.sv
`timescale 1ns/1ps
module tdff_q_merge #(
  parameter int unsigned OW = 3
) (
  input  logic            q_start,
  input  logic [1:0]      act_vld,
  input  logic [1:0][OW-1:0] act_off,
  input  logic [1:0]      cap,
  output logic            q_end,
  output logic [1:0]      q_vld,
  output logic [2*OW-1:0] q_off
);
  logic q_mid;
  logic tog0;
  logic tog1;

  assign tog0  = act_vld[0] & (cap[0] != q_start);
  assign q_mid = act_vld[0] ? cap[0] : q_start;
  assign tog1  = act_vld[1] & (cap[1] != q_mid);
  assign q_end = act_vld[1] ? cap[1] : q_mid;

  always_comb begin
    q_vld = {tog0 & tog1, tog0 | tog1};
    q_off = '0;
    if (tog0) begin
      q_off[OW-1:0] = act_off[0];
      if (tog1) q_off[2*OW-1:OW] = act_off[1];
    end else if (tog1) begin
      q_off[OW-1:0] = act_off[1];
    end
  end
endmodule

// File: rtl/tdff_loop_brk.sv
`timescale 1ns/1ps
module tdff_loop_brk #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= INIT;
    else     q <= d;
  end
endmodule

// File: rtl/timed_dff.sv
`timescale 1ns/1ps
module timed_dff
  import tdff_pkg::*;
#(
  parameter int unsigned OFF_W     = 3,
  parameter int unsigned CLK_SLOTS = 4,
  parameter int unsigned DAT_SLOTS = 2,
  parameter tdff_edge_e  EDGE_MODE = EDGE_RISE,
  parameter bit          INIT_Q    = 1'b0
) (
  input  logic                       ref_clk,
  input  logic                       rst,
  input  logic                       eclk_lvl,
  input  logic [CLK_SLOTS-1:0]       eclk_vld,
  input  logic [CLK_SLOTS*OFF_W-1:0] eclk_off,
  input  logic                       ed_lvl,
  input  logic [DAT_SLOTS-1:0]       ed_vld,
  input  logic [DAT_SLOTS*OFF_W-1:0] ed_off,
  output logic                       eq_lvl,
  output logic [1:0]                 eq_vld,
  output logic [2*OFF_W-1:0]         eq_off,
  output logic                       clk_err
);
  logic [ACT_SLOTS-1:0]             act_vld;
  logic [ACT_SLOTS-1:0][OFF_W-1:0]  act_off;
  logic [ACT_SLOTS-1:0]             cap;
  logic                             q_held;

  tdff_edge_find #(.OW(OFF_W), .CS(CLK_SLOTS), .MODE(EDGE_MODE)) u_edges (
    .lvl     (eclk_lvl),
    .vld     (eclk_vld),
    .off     (eclk_off),
    .act_vld (act_vld),
    .act_off (act_off),
    .bad     (clk_err)
  );

  for (genvar e = 0; e < ACT_SLOTS; e++) begin : g_sample
    tdff_level_at #(.OW(OFF_W), .DS(DAT_SLOTS)) u_lvl (
      .lvl    (ed_lvl),
      .vld    (ed_vld),
      .off    (ed_off),
      .at     (act_off[e]),
      .lvl_at (cap[e])
    );
  end

  tdff_q_merge #(.OW(OFF_W)) u_merge (
    .q_start (q_held),
    .act_vld (act_vld),
    .act_off (act_off),
    .cap     (cap),
    .q_end   (eq_lvl),
    .q_vld   (eq_vld),
    .q_off   (eq_off)
  );

  tdff_loop_brk #(.INIT(INIT_Q)) u_brk (
    .clk (ref_clk),
    .rst (rst),
    .d   (eq_lvl),
    .q   (q_held)
  );
endmodule

// File: rtl/timed_dff_chk.sv
`timescale 1ns/1ps
module timed_dff_chk #(
  parameter int unsigned OFF_W     = 3,
  parameter int unsigned CLK_SLOTS = 4,
  parameter bit          DUAL      = 1'b0
) (
  input logic                   ref_clk,
  input logic                   rst,
  input logic [CLK_SLOTS-1:0]   eclk_vld,
  input logic                   eq_lvl,
  input logic [1:0]             eq_vld,
  input logic [2*OFF_W-1:0]     eq_off,
  input logic                   clk_err
);
  logic prev_q;
  logic armed;

  always_ff @(posedge ref_clk) begin
    prev_q <= eq_lvl;
    armed  <= ~rst;
  end

  // R4
  q_continuity_chk: assert property (@(posedge ref_clk) disable iff (rst)
    armed |-> ((eq_lvl ^ (^eq_vld)) == prev_q));

  // R4
  no_edge_hold_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (eclk_vld == '0) |-> (eq_vld == 2'b00));

  // R3
  q_slot_order_chk: assert property (@(posedge ref_clk) disable iff (rst)
    eq_vld[1] |-> (eq_vld[0] && (eq_off[2*OFF_W-1:OFF_W] >= eq_off[OFF_W-1:0])));

  // R5
  single_edge_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (!DUAL) |-> ($countones(eq_vld) <= 1));

  // R7
  err_on_overfill_chk: assert property (@(posedge ref_clk) disable iff (rst)
    ($countones(eclk_vld) > 2) |-> clk_err);
endmodule

bind timed_dff timed_dff_chk #(
  .OFF_W     (OFF_W),
  .CLK_SLOTS (CLK_SLOTS),
  .DUAL      (EDGE_MODE == tdff_pkg::EDGE_BOTH)
) u_chk (
  .ref_clk  (ref_clk),
  .rst      (rst),
  .eclk_vld (eclk_vld),
  .eq_lvl   (eq_lvl),
  .eq_vld   (eq_vld),
  .eq_off   (eq_off),
  .clk_err  (clk_err)
);

// File: tb/test_timed_dff.sv
`timescale 1ns/1ps
module test_timed_dff;
  localparam int OW = 3;
  localparam int CS = 4;
  localparam int DS = 2;

  typedef struct {
    string      tag;
    logic       lvl;
    logic [1:0] vld;
    logic [2:0] o0;
    logic [2:0] o1;
    logic       err;
  } exp_t;

  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic eclk_lvl = 1'b0;
  logic [CS-1:0] eclk_vld = '0;
  logic [CS*OW-1:0] eclk_off = '0;
  logic ed_lvl = 1'b0;
  logic [DS-1:0] ed_vld = '0;
  logic [DS*OW-1:0] ed_off = '0;

  logic r_lvl, d_lvl, r_err, d_err;
  logic [1:0] r_vld, d_vld;
  logic [2*OW-1:0] r_off, d_off;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  exp_t q_rise[$];
  exp_t q_dual[$];

  always #5 ref_clk = ~ref_clk;

  timed_dff #(.OFF_W(OW), .CLK_SLOTS(CS), .DAT_SLOTS(DS)) i_timed_dff (
    .ref_clk(ref_clk), .rst(rst),
    .eclk_lvl(eclk_lvl), .eclk_vld(eclk_vld), .eclk_off(eclk_off),
    .ed_lvl(ed_lvl), .ed_vld(ed_vld), .ed_off(ed_off),
    .eq_lvl(r_lvl), .eq_vld(r_vld), .eq_off(r_off), .clk_err(r_err));

  timed_dff #(.OFF_W(OW), .CLK_SLOTS(CS), .DAT_SLOTS(DS),
              .EDGE_MODE(tdff_pkg::EDGE_BOTH)) i_timed_dff_dual (
    .ref_clk(ref_clk), .rst(rst),
    .eclk_lvl(eclk_lvl), .eclk_vld(eclk_vld), .eclk_off(eclk_off),
    .ed_lvl(ed_lvl), .ed_vld(ed_vld), .ed_off(ed_off),
    .eq_lvl(d_lvl), .eq_vld(d_vld), .eq_off(d_off), .clk_err(d_err));

  task automatic compare(input string who, input exp_t e, input logic lvl,
                         input logic [1:0] vld, input logic [2*OW-1:0] off,
                         input logic err);
    bit ok;
    ok = (lvl === e.lvl) && (vld === e.vld) && (err === e.err);
    if (ok && vld[0]) ok = (off[OW-1:0] === e.o0);
    if (ok && vld[1]) ok = (off[2*OW-1:OW] === e.o1);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got lvl=%0b vld=%b o0=%0d o1=%0d err=%0b, exp lvl=%0b vld=%b o0=%0d o1=%0d err=%0b",
               who, e.tag, lvl, vld, off[OW-1:0], off[2*OW-1:OW], err,
               e.lvl, e.vld, e.o0, e.o1, e.err);
    end
  endtask

  // monitor: pops and compares away from the active edge
  initial begin
    forever begin
      @(negedge ref_clk);
      #3;
      if (q_rise.size() > 0) compare("rise", q_rise.pop_front(), r_lvl, r_vld, r_off, r_err);
      if (q_dual.size() > 0) compare("dual", q_dual.pop_front(), d_lvl, d_vld, d_off, d_err);
    end
  end

  // driver: one reference cycle of stimulus plus expected items
  task automatic drive(input string tag,
                       input logic cl, input logic [CS-1:0] cv, input logic [CS*OW-1:0] co,
                       input logic dl, input logic [DS-1:0] dv, input logic [DS*OW-1:0] dof,
                       input logic rl, input logic [1:0] rv, input logic [2:0] ro0, input logic [2:0] ro1,
                       input logic ql, input logic [1:0] qv, input logic [2:0] qo0, input logic [2:0] qo1,
                       input logic err);
    exp_t a, b;
    @(negedge ref_clk);
    eclk_lvl = cl; eclk_vld = cv; eclk_off = co;
    ed_lvl = dl; ed_vld = dv; ed_off = dof;
    #1;
    a.tag = tag; a.lvl = rl; a.vld = rv; a.o0 = ro0; a.o1 = ro1; a.err = err;
    b.tag = tag; b.lvl = ql; b.vld = qv; b.o0 = qo0; b.o1 = qo1; b.err = err;
    q_rise.push_back(a);
    q_dual.push_back(b);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge ref_clk);
    rst = 1'b0;
    // R9 reset state, idle cycle
    drive("C0 reset R9", 0, 4'b0000, '0, 0, 2'b00, '0,
          0, 2'b00, 0, 0,  0, 2'b00, 0, 0,  0);
    // R1 R2 R3: rise at 2, fall at 6; data rises at 1
    drive("C1 capture R1 R2 R3", 0, 4'b0011, {3'd0,3'd0,3'd6,3'd2}, 1, 2'b01, {3'd0,3'd1},
          1, 2'b01, 2, 0,  1, 2'b01, 2, 0,  0);
    // R2 tie: rise at 4 with data fall at 4
    drive("C2 tie R2", 0, 4'b0011, {3'd0,3'd0,3'd5,3'd4}, 0, 2'b01, {3'd0,3'd4},
          1, 2'b00, 0, 0,  0, 2'b01, 5, 0,  0);
    // R4 no clock edge, data toggles
    drive("C3 hold R4", 0, 4'b0000, '0, 1, 2'b01, {3'd0,3'd3},
          1, 2'b00, 0, 0,  0, 2'b00, 0, 0,  0);
    // R8 offset-0 rising with data change at 0
    drive("C4 plain R8", 1, 4'b0001, '0, 0, 2'b01, '0,
          1, 2'b00, 0, 0,  1, 2'b01, 0, 0,  0);
    drive("C5 plain R8", 1, 4'b0011, '0, 1, 2'b01, '0,
          0, 2'b01, 0, 0,  0, 2'b01, 0, 0,  0);
    // R7 four clock slots: error, slots 2 and 3 ignored
    drive("C6 overfill R7", 1, 4'b1111, {3'd4,3'd3,3'd2,3'd1}, 0, 2'b11, {3'd3,3'd0},
          1, 2'b01, 2, 0,  1, 2'b01, 1, 0,  1);
    // R6 both edges toggle Q in one cycle
    drive("C7 dual R6", 1, 4'b0011, {3'd0,3'd0,3'd5,3'd2}, 1, 2'b11, {3'd4,3'd1},
          1, 2'b00, 0, 0,  1, 2'b11, 2, 5,  0);
    // R5 falling-only clock
    drive("C8 fall R5", 0, 4'b0001, {3'd0,3'd0,3'd0,3'd3}, 0, 2'b01, '0,
          1, 2'b00, 0, 0,  0, 2'b01, 3, 0,  0);
    // R3 capture at last offset, error clear
    drive("C9 late R3", 1, 4'b0001, {3'd0,3'd0,3'd0,3'd7}, 0, 2'b00, '0,
          0, 2'b01, 7, 0,  0, 2'b00, 0, 0,  0);
    // R7 misordered offsets
    drive("C10 order R7", 1, 4'b0011, {3'd0,3'd0,3'd2,3'd5}, 0, 2'b00, '0,
          0, 2'b00, 0, 0,  0, 2'b00, 0, 0,  1);
    drive("C11 idle R4", 1, 4'b0000, '0, 0, 2'b00, '0,
          0, 2'b00, 0, 0,  0, 2'b00, 0, 0,  0);
    repeat (3) @(negedge ref_clk);
    #5;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule